// File: doc/BRIEF.md
# Charging Port Load-Detect Status Timer

This block watches the digitized outputs of load-current comparators on a USB charging port and drives an active-low status line, here modelled as a pull-down enable. A system controller reads that line to keep a main supply running while a device is charging, or to share power among several ports. The block carries no analog logic. The comparators and their thresholds sit outside it, and they deliver separate flags for the assert and release thresholds. That split gives the detector hysteresis in current as well as in time.

In normal mode the status asserts once the load has stayed above the upper threshold long enough. By default that threshold is the programmed low current limit plus 75 mA, which is about 700 mA with the default limit resistor, and the hold time is 200 ms. The status releases once the load has stayed below the lower threshold of limit plus 25 mA for about 3 s. In power-wake mode the port runs from standby power with its current held near 55 mA, and the block raises a request to reduce the current limit. The status asserts when the load reaches that ceiling. It releases once the load has stayed below a release threshold of about 45 mA for about 15 s. All durations are parameters counted in millisecond ticks.

Top module: `ldst_status_timer`

## Requirements
- R1: After reset, `statusPullEn` and `limitReduce` are 0.
- R2: In normal mode (`pwMode`=0) with `enable`=1, `statusPullEn` rises on the clock edge that samples the SET_MS-th consecutive `msTick` with `aboveSet`=1, and not before.
- R3: In normal mode, an asserted status falls on the edge that samples the CLR_MS-th consecutive `msTick` with `belowClr`=1.
- R4: A tick that sees the qualifying flag low restarts the running set or clear timer from zero. A full new window is then needed.
- R5: In power-wake mode (`pwMode`=1), status rises after PW_SET_MS consecutive ticks with `pwAtCeiling`=1. The normal-mode flags have no effect in this mode.
- R6: In power-wake mode, an asserted status falls after PW_CLR_MS consecutive ticks with `pwBelowRel`=1. `belowClr` has no effect in this mode.
- R7: While `enable`=0, the status is released and all timer progress is discarded. This holds even when a final tick arrives in the same cycle.
- R8: A change of `pwMode` discards the running timer, even when the change coincides with a final tick. The status level is kept, and qualification restarts against the new mode's flags.
- R9: `limitReduce` equals `enable && pwMode` sampled at the previous clock edge.
- R10: Clock cycles without `msTick` never advance a timer or change the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low releases status and clears timers |
| pwMode | input | 1 | 1 = power-wake mode, 0 = normal mode |
| msTick | input | 1 | One-cycle pulse per millisecond |
| aboveSet | input | 1 | Normal mode: load above limit + 75 mA |
| belowClr | input | 1 | Normal mode: load below limit + 25 mA |
| pwAtCeiling | input | 1 | Power-wake: load at the 55 mA ceiling |
| pwBelowRel | input | 1 | Power-wake: load below the release threshold |
| statusPullEn | output | 1 | 1 = pull the active-low status line low (load detected) |
| limitReduce | output | 1 | Request to apply the reduced power-wake current ceiling |

## Verification
A timer can reach its final tick in the same cycle as a mode switch or a disable. The bench provokes both collisions. It brings the set timer one tick short of expiry, then drives the last `msTick` together with a `pwMode` toggle, and in a separate case together with `enable` low. In both cases the bench expects the status to stay released. It then expects a full window to be needed afterwards, which shows that the discard won over the expiry.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic {
    ST_RELEASED = 1'b0,
    ST_ASSERTED = 1'b1
  } detState_t;

  // tgtSel = {detector asserted, power-wake mode}
  typedef struct packed {
    logic       clr;
    logic       inc;
    logic [1:0] tgtSel;
  } tmrStrobe_t;

endpackage

// File: rtl/ldst_timer_dp.sv
module ldst_timer_dp
  import ldst_pkg::*;
#(
  parameter int SET_MS    = 200,
  parameter int CLR_MS    = 3000,
  parameter int PW_SET_MS = 1,
  parameter int PW_CLR_MS = 15000
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strobe,
  output logic       lastTick
);

  localparam int MAX_A = (SET_MS > CLR_MS) ? SET_MS : CLR_MS;
  localparam int MAX_B = (PW_SET_MS > PW_CLR_MS) ? PW_SET_MS : PW_CLR_MS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int NUM_TGT = 4;

  logic [CNT_W-1:0]   count;
  logic [NUM_TGT-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clr) begin
      count <= '0;
    end else if (strobe.inc) begin
      count <= count + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_hit
    localparam int TGT = (g == 0) ? SET_MS :
                         (g == 1) ? PW_SET_MS :
                         (g == 2) ? CLR_MS : PW_CLR_MS;
    assign hitVec[g] = (count == CNT_W'(TGT - 1));
  end

  assign lastTick = hitVec[strobe.tgtSel];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(MAX_T - 1));

  assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (count == '0));

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       pwMode,
  input  logic       msTick,
  input  logic       aboveSet,
  input  logic       belowClr,
  input  logic       pwAtCeiling,
  input  logic       pwBelowRel,
  input  logic       lastTick,
  output tmrStrobe_t strobe,
  output logic       statusPullEn
);

  detState_t state;
  logic      modePrev;
  logic      modeChg;
  logic      qualCond;
  logic      live;
  logic      fire;

  assign modeChg = (pwMode != modePrev);

  always_comb begin
    if (state == ST_RELEASED) begin
      qualCond = pwMode ? pwAtCeiling : aboveSet;
    end else begin
      qualCond = pwMode ? pwBelowRel : belowClr;
    end
  end

  assign live = enable && !modeChg && qualCond;
  assign fire = live && msTick && lastTick;

  always_comb begin
    strobe.tgtSel = {state == ST_ASSERTED, pwMode};
    strobe.clr    = !live || fire;
    strobe.inc    = live && msTick && !lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RELEASED;
      modePrev <= 1'b0;
    end else begin
      modePrev <= pwMode;
      if (!enable) begin
        state <= ST_RELEASED;
      end else if (fire) begin
        state <= (state == ST_RELEASED) ? ST_ASSERTED : ST_RELEASED;
      end
    end
  end

  assign statusPullEn = (state == ST_ASSERTED);

  assert_release_on_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !statusPullEn);

  assert_change_needs_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (statusPullEn != $past(statusPullEn))) |-> $past(msTick));

  assert_rise_needs_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusPullEn) |-> $past(pwMode ? pwAtCeiling : aboveSet));

  assert_fall_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(statusPullEn) && $past(enable)) |-> $past(pwMode ? pwBelowRel : belowClr));

  assert_mode_change_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && modeChg) |=> $stable(statusPullEn));

endmodule

// File: rtl/ldst_status_timer.sv
module ldst_status_timer
  import ldst_pkg::*;
#(
  parameter int SET_MS    = 200,
  parameter int CLR_MS    = 3000,
  parameter int PW_SET_MS = 1,
  parameter int PW_CLR_MS = 15000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic pwMode,
  input  logic msTick,
  input  logic aboveSet,
  input  logic belowClr,
  input  logic pwAtCeiling,
  input  logic pwBelowRel,
  output logic statusPullEn,
  output logic limitReduce
);

  tmrStrobe_t strobe;
  logic       lastTick;

  ldst_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .pwMode       (pwMode),
    .msTick       (msTick),
    .aboveSet     (aboveSet),
    .belowClr     (belowClr),
    .pwAtCeiling  (pwAtCeiling),
    .pwBelowRel   (pwBelowRel),
    .lastTick     (lastTick),
    .strobe       (strobe),
    .statusPullEn (statusPullEn)
  );

  ldst_timer_dp #(
    .SET_MS    (SET_MS),
    .CLR_MS    (CLR_MS),
    .PW_SET_MS (PW_SET_MS),
    .PW_CLR_MS (PW_CLR_MS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lastTick (lastTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReduce <= 1'b0;
    end else begin
      limitReduce <= enable && pwMode;
    end
  end

  assert_limit_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && pwMode) |=> limitReduce);

  assert_limit_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && pwMode) |=> !limitReduce);

endmodule

// File: tb/ldst_status_timer_tb.sv
module ldst_status_timer_tb_top;

  localparam int SET_T   = 5;
  localparam int CLR_T   = 8;
  localparam int PWSET_T = 2;
  localparam int PWCLR_T = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic pwMode = 1'b0;
  logic msTick = 1'b0;
  logic aboveSet = 1'b0;
  logic belowClr = 1'b0;
  logic pwAtCeiling = 1'b0;
  logic pwBelowRel = 1'b0;
  logic statusPullEn;
  logic limitReduce;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ldst_status_timer #(
    .SET_MS(SET_T), .CLR_MS(CLR_T), .PW_SET_MS(PWSET_T), .PW_CLR_MS(PWCLR_T)
  ) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .pwMode(pwMode), .msTick(msTick),
    .aboveSet(aboveSet), .belowClr(belowClr), .pwAtCeiling(pwAtCeiling),
    .pwBelowRel(pwBelowRel), .statusPullEn(statusPullEn), .limitReduce(limitReduce)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setFlags(input logic a, input logic b, input logic c, input logic d);
    @(negedge clk);
    aboveSet = a; belowClr = b; pwAtCeiling = c; pwBelowRel = d;
  endtask

  task automatic t_reset();
    check("R1", "status after reset", statusPullEn, 1'b0);
    check("R1", "limitReduce after reset", limitReduce, 1'b0);
  endtask

  task automatic t_normalSet();
    enable = 1'b1; pwMode = 1'b0;
    setFlags(1, 0, 0, 0);
    ticks(SET_T - 1);
    check("R2", "status one tick early", statusPullEn, 1'b0);
    idle(20);
    check("R10", "status after tickless cycles", statusPullEn, 1'b0);
    ticks(1);
    check("R2", "status at set window", statusPullEn, 1'b1);
  endtask

  task automatic t_normalClear();
    setFlags(0, 1, 0, 0);
    ticks(CLR_T - 1);
    check("R3", "status one tick before release", statusPullEn, 1'b1);
    ticks(1);
    check("R3", "status at clear window", statusPullEn, 1'b0);
  endtask

  task automatic t_excursion();
    setFlags(1, 0, 0, 0);
    ticks(3);
    setFlags(0, 0, 0, 0);
    ticks(1);
    setFlags(1, 0, 0, 0);
    ticks(SET_T - 1);
    check("R4", "set timer restarted", statusPullEn, 1'b0);
    ticks(1);
    check("R4", "set after full window", statusPullEn, 1'b1);
    setFlags(0, 1, 0, 0);
    ticks(3);
    setFlags(0, 0, 0, 0);
    ticks(1);
    setFlags(0, 1, 0, 0);
    ticks(CLR_T - 1);
    check("R4", "clear timer restarted", statusPullEn, 1'b1);
    ticks(1);
    check("R4", "clear after full window", statusPullEn, 1'b0);
  endtask

  task automatic t_powerWake();
    @(negedge clk) pwMode = 1'b1;
    setFlags(1, 0, 0, 0);
    check("R9", "limitReduce in power-wake", limitReduce, 1'b1);
    ticks(SET_T + 2);
    check("R5", "normal set flag ignored", statusPullEn, 1'b0);
    setFlags(0, 0, 1, 0);
    ticks(PWSET_T - 1);
    check("R5", "pw set one tick early", statusPullEn, 1'b0);
    ticks(1);
    check("R5", "pw set at window", statusPullEn, 1'b1);
    setFlags(0, 1, 0, 0);
    ticks(PWCLR_T + 2);
    check("R6", "normal clear flag ignored", statusPullEn, 1'b1);
    setFlags(0, 0, 0, 1);
    ticks(PWCLR_T - 1);
    check("R6", "pw release one tick early", statusPullEn, 1'b1);
    ticks(1);
    check("R6", "pw release at window", statusPullEn, 1'b0);
    @(negedge clk) pwMode = 1'b0;
    @(negedge clk);
    check("R9", "limitReduce back in normal", limitReduce, 1'b0);
  endtask

  task automatic t_modeChange();
    setFlags(1, 0, 1, 0);
    ticks(SET_T - 1);
    @(negedge clk) begin msTick = 1'b1; pwMode = 1'b1; end
    @(negedge clk) msTick = 1'b0;
    check("R8", "final tick with mode switch", statusPullEn, 1'b0);
    @(negedge clk) pwMode = 1'b0;
    @(negedge clk);
    ticks(SET_T - 1);
    check("R8", "full window needed after switch", statusPullEn, 1'b0);
    ticks(1);
    check("R8", "set after switch window", statusPullEn, 1'b1);
    setFlags(0, 0, 0, 0);
    @(negedge clk) pwMode = 1'b1;
    ticks(2);
    check("R8", "status held across switch", statusPullEn, 1'b1);
    setFlags(0, 0, 0, 1);
    ticks(PWCLR_T);
    check("R6", "pw release after switch", statusPullEn, 1'b0);
    @(negedge clk) pwMode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    setFlags(1, 0, 0, 0);
    ticks(SET_T);
    check("R2", "set before disable", statusPullEn, 1'b1);
    @(negedge clk) pwMode = 1'b1;
    setFlags(0, 0, 1, 0);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check("R7", "status released on disable", statusPullEn, 1'b0);
    check("R7", "limitReduce off on disable", limitReduce, 1'b0);
    ticks(PWSET_T + 1);
    check("R7", "no set while disabled", statusPullEn, 1'b0);
    @(negedge clk) begin enable = 1'b1; pwMode = 1'b0; end
    setFlags(1, 0, 0, 0);
    ticks(SET_T - 1);
    @(negedge clk) begin msTick = 1'b1; enable = 1'b0; end
    @(negedge clk) begin msTick = 1'b0; enable = 1'b1; end
    check("R7", "final tick with disable", statusPullEn, 1'b0);
    ticks(SET_T - 1);
    check("R7", "progress discarded", statusPullEn, 1'b0);
    ticks(1);
    check("R7", "set after re-enable", statusPullEn, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    t_normalSet();
    t_normalClear();
    t_excursion();
    t_powerWake();
    t_modeChange();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule